// File: doc/BRIEF.md
# Two-Accumulator Arithmetic and Logic Unit

This block computes the next value of the primary accumulator of a small two-accumulator processor. The control sequencer presents both accumulator values and a 6-bit operation code and pulses `start` for one cycle. The block answers with a one-cycle `done` pulse. From that pulse until the next accepted `start`, `result` holds the new value.

Add, subtract, multiply, bitwise logic, shifts and rotates settle in one cycle. Quotient and remainder come from a restoring divider that processes one bit per clock. Exponentiation repeats a multiplication once per unit of the exponent. Several operations read only part of an operand:
- multiply reads the low nibbles of both operands;
- power reads the low three bits of both operands;
- shifts and rotates read the low three bits of the second operand.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0x20 returns a+b and opcode 0x21 returns a-b. Both are 8-bit two's complement and wrap modulo 256.
- R2: Opcode 0x22 returns the unsigned product a[3:0]*b[3:0]. The upper nibbles of both operands have no effect.
- R3: Opcode 0x23 returns the unsigned quotient a/b and opcode 0x24 the unsigned remainder a%b. For either, done is high in the 9th cycle after the cycle in which start was high, and only in that cycle.
- R4: With b equal to zero, the quotient is 0xFF and the remainder equals a.
- R5: Opcode 0x25 returns a[2:0] raised to the power b[2:0], truncated to 8 bits, where 0 to the power 0 is 1. Done is high 2+b[2:0] cycles after the start cycle.
- R6: Opcodes 0x28, 0x29, 0x2A and 0x2B return NOT a, a AND b, a OR b and a XOR b.
- R7: Opcode 0x2C shifts a left and opcode 0x2E shifts a right, both logically, by b[2:0] places with zero fill.
- R8: Opcode 0x2D rotates a left and opcode 0x2F rotates a right by b[2:0] places.
- R9: Every opcode other than 0x23, 0x24 and 0x25 raises done for exactly one cycle, in the cycle right after start.
- R10: While a divide or power operation is in progress, start is ignored. The running operation's result and timing are unchanged, and the ignored start produces no done pulse.
- R11: After reset, done is 0 and result is 0x00.
- R12: Any opcode outside 0x20 to 0x25 and 0x28 to 0x2F returns a unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| opcode | input | 6 | Operation select |
| acc_a | input | 8 | First accumulator operand |
| acc_b | input | 8 | Second accumulator operand |
| result | output | 8 | New first-accumulator value, held after done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The operations are driven with four kinds of operands:
- Values near the signed and unsigned wrap points show whether add and subtract truncate correctly.
- Operands with junk in their upper bits show whether multiply, power, shift and rotate read only the documented low bits.
- Divisions with a small dividend, a divisor of one and a divisor of zero separate a true restoring divider from one that mishandles the final bit or the zero case.
- A second start issued during a division shows whether the sequencer wrongly accepts new work while busy.

Latency is measured on every operation, so a divider that runs the wrong number of iterations fails even when its quotient is correct.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW  = 8;
  localparam int SHW = $clog2(DW);
  localparam int NBW = DW / 2;

  typedef enum logic [5:0] {
    OP_ADD = 6'h20, OP_SUB = 6'h21, OP_MUL = 6'h22, OP_DIV = 6'h23,
    OP_MOD = 6'h24, OP_POW = 6'h25, OP_NOT = 6'h28, OP_AND = 6'h29,
    OP_OR  = 6'h2A, OP_XOR = 6'h2B, OP_SHL = 6'h2C, OP_ROL = 6'h2D,
    OP_SHR = 6'h2E, OP_ROR = 6'h2F
  } alu_op_e;

  typedef enum logic [1:0] {SEL_FAST, SEL_QUO, SEL_REM, SEL_POW} res_sel_e;

  // Single-cycle operations; unknown codes pass operand a through.
  function automatic logic [DW-1:0] fast_eval(input logic [5:0] op,
                                              input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
    logic [SHW-1:0]  s;
    logic [2*DW-1:0] dbl;
    logic [DW-1:0]   r;
    s   = b[SHW-1:0];
    dbl = '0;
    case (op)
      OP_ADD: r = a + b;
      OP_SUB: r = a - b;
      OP_MUL: r = DW'(a[NBW-1:0]) * DW'(b[NBW-1:0]);
      OP_NOT: r = ~a;
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_SHL: r = a << s;
      OP_SHR: r = a >> s;
      OP_ROL: begin dbl = {a, a} << s; r = dbl[2*DW-1:DW]; end
      OP_ROR: begin dbl = {a, a} >> s; r = dbl[DW-1:0];    end
      default: r = a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/acc_alu_fast.sv
module acc_alu_fast
  import acc_alu_pkg::*;
(
  input  logic [5:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb y = fast_eval(op, a, b);

  always_comb begin
    if (op == OP_AND) a_and_sub_r6: assert ((y & ~a) == '0);
  end
endmodule

// File: rtl/acc_alu_div.sv
module acc_alu_div
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          busy,
  output logic          fin
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial, diff;
  logic          fits;

  assign trial = {rem, quo[DW-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo <= '0; rem <= '0; dvs_q <= '0; cnt_q <= '0; busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem <= '0; quo <= dividend; dvs_q <= divisor;
        cnt_q <= CW'(DW); busy <= 1'b1;
      end else if (busy) begin
        rem   <= fits ? diff[DW-1:0] : trial[DW-1:0];
        quo   <= {quo[DW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dvs_q != '0) |-> (rem < dvs_q));
  p_zero_divisor_quo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dvs_q == '0) |-> (quo == '1));
endmodule

// File: rtl/acc_alu_pow.sv
module acc_alu_pow
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [SHW-1:0] base,
  input  logic [SHW-1:0] expo,
  output logic [DW-1:0]  acc,
  output logic           busy,
  output logic           fin
);
  logic [SHW-1:0] base_q, cnt_q;
  logic [DW-1:0]  prod;

  assign prod = acc * DW'(base_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; base_q <= '0; cnt_q <= '0; busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= DW'(1); base_q <= base; cnt_q <= expo; busy <= 1'b1;
      end else if (busy) begin
        if (cnt_q != '0) begin
          acc   <= prod;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  p_zero_exp_fin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && expo == '0) |-> ##2 (fin && acc == DW'(1)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [5:0] opcode,
  input  logic [7:0] acc_a,
  input  logic [7:0] acc_b,
  output logic [7:0] result,
  output logic       done
);
  logic [DW-1:0] fast_y, fast_q, quo, rem, pw;
  logic          div_busy, div_fin, pow_busy, pow_fin, fast_done_q;
  logic          busy, accept, is_div, is_mod, is_pow, div_go, pow_go;
  res_sel_e      sel_q;

  assign busy   = div_busy | pow_busy;
  assign accept = start & ~busy;
  assign is_div = opcode == OP_DIV;
  assign is_mod = opcode == OP_MOD;
  assign is_pow = opcode == OP_POW;
  assign div_go = accept & (is_div | is_mod);
  assign pow_go = accept & is_pow;

  acc_alu_fast u_fast (.op(opcode), .a(acc_a), .b(acc_b), .y(fast_y));

  acc_alu_div u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(acc_a), .divisor(acc_b),
    .quo(quo), .rem(rem), .busy(div_busy), .fin(div_fin));

  acc_alu_pow u_pow (
    .clk(clk), .rst_n(rst_n), .go(pow_go), .base(acc_a[SHW-1:0]),
    .expo(acc_b[SHW-1:0]), .acc(pw), .busy(pow_busy), .fin(pow_fin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0; fast_done_q <= 1'b0; sel_q <= SEL_FAST;
    end else begin
      fast_done_q <= 1'b0;
      if (accept) begin
        if (is_div)      sel_q <= SEL_QUO;
        else if (is_mod) sel_q <= SEL_REM;
        else if (is_pow) sel_q <= SEL_POW;
        else begin
          sel_q       <= SEL_FAST;
          fast_q      <= fast_y;
          fast_done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_QUO: result = quo;
      SEL_REM: result = rem;
      SEL_POW: result = pw;
      default: result = fast_q;
    endcase
  end
  assign done = fast_done_q | div_fin | pow_fin;

  p_fast_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(is_div || is_mod || is_pow)) |=> done);
  p_done_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fast_done_q, div_fin, pow_fin}));
  p_one_unit_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_busy, pow_busy}));
  p_busy_holds_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_fin && !pow_fin) |=> $stable(sel_q));
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] opcode = '0;
  logic [7:0] acc_a = '0, acc_b = '0;
  logic [7:0] result;
  logic       done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  acc_alu dut_i (.clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
                 .acc_a(acc_a), .acc_b(acc_b), .result(result), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rot(input logic [7:0] a, input int s, input bit left);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      if (left) r[(i + s) % 8] = a[i]; else r[i] = a[(i + s) % 8];
    return r;
  endfunction

  function automatic logic [7:0] powm(input int bs, input int e);
    int p = 1;
    for (int i = 0; i < e; i++) p = (p * bs) % 256;
    return 8'(p);
  endfunction

  // Issue one operation; returns result and the cycle number in which done rose.
  task automatic run(input logic [5:0] op, input logic [7:0] a, input logic [7:0] b,
                     output logic [7:0] res, output int lat);
    @(negedge clk);
    opcode = op; acc_a = a; acc_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    res = result;
  endtask

  task automatic expect_op(input logic [5:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] exp, input int exp_lat, input string req);
    logic [7:0] r; int lat;
    run(op, a, b, r, lat);
    check(r == exp, req, r, exp);
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    @(negedge clk);
    check(!done, {req, " done width"}, done, 0);
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R11 done", done, 0);
    check(result == 8'h00, "R11 result", result, 0);
  endtask

  task automatic t_arith;
    expect_op(6'h20, 8'h7F, 8'h01, 8'h80, 1, "R1 add");
    expect_op(6'h20, 8'hFF, 8'h01, 8'h00, 1, "R1 add wrap");
    expect_op(6'h21, 8'h00, 8'h01, 8'hFF, 1, "R1 sub");
    expect_op(6'h22, 8'hF3, 8'h2E, 8'd42, 1, "R2 mul nibbles");
    expect_op(6'h22, 8'h0F, 8'hFF, 8'd225, 1, "R2 mul max");
  endtask

  task automatic t_div;
    expect_op(6'h23, 8'd200, 8'd7, 8'd28, 9, "R3 quo");
    expect_op(6'h24, 8'd200, 8'd7, 8'd4, 9, "R3 rem");
    expect_op(6'h23, 8'd7, 8'd200, 8'd0, 9, "R3 small quo");
    expect_op(6'h24, 8'd255, 8'd1, 8'd0, 9, "R3 rem by one");
    expect_op(6'h23, 8'd255, 8'd1, 8'd255, 9, "R3 quo by one");
    expect_op(6'h23, 8'h5A, 8'h00, 8'hFF, 9, "R4 quo by zero");
    expect_op(6'h24, 8'h5A, 8'h00, 8'h5A, 9, "R4 rem by zero");
  endtask

  task automatic t_pow;
    expect_op(6'h25, 8'h00, 8'h00, powm(0, 0), 2, "R5 zero to zero");
    expect_op(6'h25, 8'hFA, 8'h0B, powm(2, 3), 5, "R5 low bits");
    expect_op(6'h25, 8'h02, 8'h07, powm(2, 7), 9, "R5 2^7");
    expect_op(6'h25, 8'h07, 8'h07, powm(7, 7), 9, "R5 truncation");
    expect_op(6'h25, 8'h00, 8'h03, powm(0, 3), 5, "R5 zero base");
  endtask

  task automatic t_logic;
    expect_op(6'h28, 8'hA5, 8'h00, ~8'hA5, 1, "R6 not");
    expect_op(6'h29, 8'hCC, 8'hAA, 8'hCC & 8'hAA, 1, "R6 and");
    expect_op(6'h2A, 8'hCC, 8'hAA, 8'hCC | 8'hAA, 1, "R6 or");
    expect_op(6'h2B, 8'hCC, 8'hAA, 8'hCC ^ 8'hAA, 1, "R6 xor");
  endtask

  task automatic t_shift;
    expect_op(6'h2C, 8'hB1, 8'hFB, 8'h88, 1, "R7 shl by 3");
    expect_op(6'h2E, 8'hB1, 8'h0B, 8'h16, 1, "R7 shr by 3");
    expect_op(6'h2C, 8'hB1, 8'h08, 8'hB1, 1, "R7 shl by 0");
    expect_op(6'h2D, 8'hB1, 8'h0B, rot(8'hB1, 3, 1), 1, "R8 rol");
    expect_op(6'h2F, 8'hB1, 8'h0B, rot(8'hB1, 3, 0), 1, "R8 ror");
    expect_op(6'h2F, 8'h81, 8'h07, rot(8'h81, 7, 0), 1, "R8 ror by 7");
  endtask

  task automatic t_busy;
    int lat = 1, extra = 0;
    @(negedge clk);
    opcode = 6'h23; acc_a = 8'd100; acc_b = 8'd7; start = 1'b1;
    @(negedge clk);
    opcode = 6'h20; acc_a = 8'd1; acc_b = 8'd1;
    @(negedge clk);
    start = 1'b0; lat = 2;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    check(result == 8'd14, "R10 busy result", result, 14);
    check(lat == 9, "R10 busy latency", lat, 9);
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (done) extra++; end
    check(extra == 0, "R10 no extra done", extra, 0);
  endtask

  task automatic t_pass;
    expect_op(6'h00, 8'h3C, 8'h11, 8'h3C, 1, "R12 nop code");
    expect_op(6'h30, 8'h9E, 8'h11, 8'h9E, 1, "R12 compare code");
    expect_op(6'h27, 8'h42, 8'hFF, 8'h42, 1, "R12 gap code");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_div();
    t_pow();
    t_logic();
    t_shift();
    t_busy();
    t_pass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule